// File: doc/BRIEF.md
# Idle-Detect Low-Power Mode Controller

This controller decides when a synchronous rectifier stage should stop gating and drop into a low-power mode, and when it should come back. It watches a one-cycle pulse, `sw_edge`, raised once per switching cycle by the drain-voltage sensing logic. It also measures the spacing between those pulses. When switching stops for long enough, the block arms. If the silence then lasts through a further debounce window, it raises `lp_mode` and drops `rect_en`.

While in low power, the controller leaves the mode in either of two ways. The first is a short quiet gap between bursts: a period longer than a normal switching period but shorter than the exit limit. The second is an unbroken run of seven normal-length switching periods. All limits are given as parameters in clock counts, with one set for a fast variant and one for a slow variant. The `slow_variant` input picks the set.

Top module: `idle_lp_ctrl`

## Requirements
- R1: During and right after reset, `lp_mode` is 0 and `rect_en` is 1. The idle timer starts counting from the release of reset as if a pulse had just been seen.
- R2: With the fast limits, `lp_mode` rises exactly IDLE+DEB clock edges after the edge that sampled the last `sw_edge` pulse (defaults 80+180), and not one edge earlier.
- R3: With `slow_variant`=1, the slow limits apply: entry after 160+320 quiet cycles, normal period at most 40 and exit gap below 80.
- R4: A pulse that arrives during the debounce window cancels entry. `lp_mode` stays 0, and the full idle and debounce time is counted again from that pulse.
- R5: A pulse that arrives before the idle time has expired restarts the idle count from zero.
- R6: In low power, a pulse whose period (cycles since the previous pulse) is greater than the normal limit and less than the exit-gap limit clears `lp_mode` on the clock edge that samples it.
- R7: In low power, the seventh consecutive pulse with a normal period (at most the normal limit) clears `lp_mode` on the clock edge that samples it.
- R8: A period above the normal limit resets the consecutive-cycle count to zero. A period at or above the exit-gap limit leaves `lp_mode` set.
- R9: Boundaries: a period equal to the normal limit counts as normal, and a period equal to the exit-gap limit is not a short gap.
- R10: `rect_en` is always the inverse of `lp_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_edge | input | 1 | One-cycle pulse per detected switching edge |
| slow_variant | input | 1 | 0 selects the fast limit set, 1 selects the slow set |
| lp_mode | output | 1 | Low-power mode flag |
| rect_en | output | 1 | Rectifier gating enable |

## Verification
Both exit conditions act on the same clock edge that samples the exit pulse, so `lp_mode` is checked at the falling edge just after that pulse's sampling edge. Entry is a pure count: the flag is checked low after IDLE+DEB-1 quiet cycles and high after IDLE+DEB, which pins the count exactly with no slack. The bench drives and samples only on falling edges, and it steps a cycle-level model of the quiet-time counter, the run counter and the mode flag once per cycle. Every cycle's output is therefore compared with the value due for that very cycle.

// File: rtl/idle_lp_pkg.sv
package idle_lp_pkg;

  typedef logic [15:0] tick_t;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_ARMED  = 2'd1,
    ST_LOWPWR = 2'd2
  } lp_state_e;

  // a period up to and including the limit is ordinary switching
  function automatic logic period_normal(tick_t per, tick_t nrm_lim);
    return per <= nrm_lim;
  endfunction

  // a quiet gap between bursts: longer than normal, shorter than the exit limit
  function automatic logic period_short_gap(tick_t per, tick_t nrm_lim, tick_t gap_lim);
    return (per > nrm_lim) && (per < gap_lim);
  endfunction

  function automatic tick_t pick_limit(logic slow, tick_t fast_v, tick_t slow_v);
    return slow ? slow_v : fast_v;
  endfunction

endpackage

// File: rtl/lp_gap_timer.sv
module lp_gap_timer
  import idle_lp_pkg::*;
#(
  parameter int SAT = 320
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sw_edge,
  output tick_t gap_q,
  output tick_t period
);
  localparam tick_t SAT_T = tick_t'(SAT);

  always_ff @(posedge clk) begin
    if (!rst_n)               gap_q <= '0;
    else if (sw_edge)         gap_q <= '0;
    else if (gap_q < SAT_T)   gap_q <= gap_q + tick_t'(1);
  end

  // cycles between the previous sampled pulse and this one
  assign period = gap_q + tick_t'(1);

  // R5
  gap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_edge |=> (gap_q == '0));

  // R5
  gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= SAT_T);

endmodule

// File: rtl/lp_run_counter.sv
module lp_run_counter #(
  parameter int CYCLES = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_edge,
  input  logic is_normal,
  output logic run_hit
);
  localparam int RW = $clog2(CYCLES + 1);
  localparam logic [RW-1:0] TOP  = RW'(CYCLES);
  localparam logic [RW-1:0] LAST = RW'(CYCLES - 1);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else if (sw_edge) begin
      if (!is_normal)       run_q <= '0;
      else if (run_q < TOP) run_q <= run_q + RW'(1);
    end
  end

  assign run_hit = sw_edge && is_normal && (run_q >= LAST);

  // R8
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_edge && !is_normal) |=> (run_q == '0));

  // R7
  run_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= TOP);

endmodule

// File: rtl/lp_mode_fsm.sv
module lp_mode_fsm
  import idle_lp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sw_edge,
  input  tick_t gap_q,
  input  tick_t idle_lim,
  input  tick_t deb_lim,
  input  logic  short_gap,
  input  logic  run_hit,
  output logic  lp_mode
);
  lp_state_e state_q, state_d;
  tick_t     deb_q, deb_d;

  logic idle_done, deb_done, exit_req;
  assign idle_done = !sw_edge && (gap_q >= idle_lim - tick_t'(1));
  assign deb_done  = deb_q >= deb_lim - tick_t'(1);
  assign exit_req  = sw_edge && (short_gap || run_hit);

  always_comb begin
    state_d = state_q;
    deb_d   = deb_q;
    unique case (state_q)
      ST_ACTIVE: if (idle_done) begin
        state_d = ST_ARMED;
        deb_d   = '0;
      end
      ST_ARMED: begin
        if (sw_edge)       state_d = ST_ACTIVE;
        else if (deb_done) state_d = ST_LOWPWR;
        else               deb_d   = deb_q + tick_t'(1);
      end
      ST_LOWPWR: if (exit_req) state_d = ST_ACTIVE;
      default: state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_ACTIVE;
      deb_q   <= '0;
    end else begin
      state_q <= state_d;
      deb_q   <= deb_d;
    end
  end

  assign lp_mode = (state_q == ST_LOWPWR);

  // R2
  arm_before_lp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lp_mode) |-> ($past(state_q) == ST_ARMED));

  // R4
  deb_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARMED && sw_edge) |=> (state_q == ST_ACTIVE && !lp_mode));

  // R5
  active_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACTIVE && sw_edge) |=> (state_q == ST_ACTIVE));

  // R6
  short_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode && sw_edge && short_gap) |=> !lp_mode);

  // R7
  run_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode && run_hit) |=> !lp_mode);

  // R8
  lp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_mode && !short_gap && !run_hit) |=> lp_mode);

endmodule

// File: rtl/idle_lp_ctrl.sv
module idle_lp_ctrl
  import idle_lp_pkg::*;
#(
  parameter int FAST_IDLE = 80,
  parameter int FAST_DEB  = 180,
  parameter int FAST_GAP  = 40,
  parameter int FAST_NORM = 20,
  parameter int SLOW_IDLE = 160,
  parameter int SLOW_DEB  = 320,
  parameter int SLOW_GAP  = 80,
  parameter int SLOW_NORM = 40,
  parameter int EXIT_RUN  = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_edge,
  input  logic slow_variant,
  output logic lp_mode,
  output logic rect_en
);
  localparam int M_A = (FAST_IDLE > FAST_DEB) ? FAST_IDLE : FAST_DEB;
  localparam int M_B = (SLOW_IDLE > SLOW_DEB) ? SLOW_IDLE : SLOW_DEB;
  localparam int M_C = (FAST_GAP > SLOW_GAP) ? FAST_GAP : SLOW_GAP;
  localparam int M_D = (M_A > M_B) ? M_A : M_B;
  localparam int GAP_SAT = (M_D > M_C) ? M_D : M_C;

  tick_t idle_lim, deb_lim, gap_lim, nrm_lim;
  tick_t gap_q, period;
  logic  is_normal, short_gap, run_hit;

  assign idle_lim = pick_limit(slow_variant, tick_t'(FAST_IDLE), tick_t'(SLOW_IDLE));
  assign deb_lim  = pick_limit(slow_variant, tick_t'(FAST_DEB),  tick_t'(SLOW_DEB));
  assign gap_lim  = pick_limit(slow_variant, tick_t'(FAST_GAP),  tick_t'(SLOW_GAP));
  assign nrm_lim  = pick_limit(slow_variant, tick_t'(FAST_NORM), tick_t'(SLOW_NORM));

  lp_gap_timer #(.SAT(GAP_SAT)) u_gap (
    .clk(clk), .rst_n(rst_n), .sw_edge(sw_edge),
    .gap_q(gap_q), .period(period)
  );

  assign is_normal = period_normal(period, nrm_lim);
  assign short_gap = period_short_gap(period, nrm_lim, gap_lim);

  lp_run_counter #(.CYCLES(EXIT_RUN)) u_run (
    .clk(clk), .rst_n(rst_n), .sw_edge(sw_edge),
    .is_normal(is_normal), .run_hit(run_hit)
  );

  lp_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sw_edge(sw_edge), .gap_q(gap_q),
    .idle_lim(idle_lim), .deb_lim(deb_lim), .short_gap(short_gap),
    .run_hit(run_hit), .lp_mode(lp_mode)
  );

  assign rect_en = !lp_mode;

endmodule

// File: tb/idle_lp_ctrl_bench.sv
module idle_lp_ctrl_bench;
  localparam int FI = 80,  FD = 180, FG = 40, FN = 20;
  localparam int SI = 160, SD = 320, SG = 80, SN = 40;
  localparam int RUN = 7;

  logic clk = 0, rst_n = 0, sw_edge = 0, slow_variant = 0;
  logic lp_mode, rect_en;
  int checks = 0, failures = 0;
  bit done = 0;

  // model state
  int m_t, m_run;
  bit m_lp;

  idle_lp_ctrl u_idle_lp_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_edge(sw_edge), .slow_variant(slow_variant),
    .lp_mode(lp_mode), .rect_en(rect_en)
  );

  always #5 clk = ~clk;

  function automatic int l_idle(); return slow_variant ? SI : FI; endfunction
  function automatic int l_deb();  return slow_variant ? SD : FD; endfunction
  function automatic int l_gap();  return slow_variant ? SG : FG; endfunction
  function automatic int l_nrm();  return slow_variant ? SN : FN; endfunction

  task automatic check(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_t = 0; m_run = 0; m_lp = 0;
  endtask

  // drive one cycle, advance the model, compare at the falling edge
  task automatic step(bit v, string tag);
    sw_edge = v;
    @(negedge clk);
    if (v) begin
      int per = m_t + 1;
      bit nrm = per <= l_nrm();
      bit sgap = (per > l_nrm()) && (per < l_gap());
      m_run = nrm ? ((m_run + 1 > RUN) ? RUN : m_run + 1) : 0;
      if (m_lp && ((nrm && m_run >= RUN) || sgap)) m_lp = 0;
      m_t = 0;
    end else begin
      if (m_t < 1000000) m_t++;
      if (!m_lp && m_t == l_idle() + l_deb()) m_lp = 1;
    end
    check(tag, lp_mode, m_lp);
    check("R10", rect_en, !m_lp);
  endtask

  task automatic quiet(int n, string tag);
    for (int i = 0; i < n; i++) step(0, tag);
  endtask

  task automatic pulse_after(int per, string tag);
    quiet(per - 1, tag);
    step(1, tag);
  endtask

  task automatic do_reset();
    sw_edge = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1", lp_mode, 1'b0);
    check("R1", rect_en, 1'b1);
    rst_n = 1;
    model_reset();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    do_reset();
    quiet(5, "R1");
    check("R1", lp_mode, 1'b0);

    // R5: restart before idle expires, then R2 exact entry count
    step(1, "R5");
    pulse_after(FI - 1, "R5");
    quiet(FI + FD - 1, "R2");
    check("R2", lp_mode, 1'b0);
    step(0, "R2");
    check("R2", lp_mode, 1'b1);
    check("R10", rect_en, 1'b0);

    // R8 long period holds, R9 period == gap limit holds, R6 short gap exits
    pulse_after(500, "R8");
    check("R8", lp_mode, 1'b1);
    pulse_after(FG, "R9");
    check("R9", lp_mode, 1'b1);
    pulse_after(FN + 1, "R6");
    check("R6", lp_mode, 1'b0);

    // re-enter, then run counter with reset by a non-normal period
    quiet(FI + FD, "R2");
    check("R2", lp_mode, 1'b1);
    pulse_after(400, "R8");
    for (int i = 0; i < 6; i++) pulse_after(FN, "R9");
    check("R9", lp_mode, 1'b1);
    pulse_after(FG, "R8");
    check("R8", lp_mode, 1'b1);
    for (int i = 0; i < 6; i++) pulse_after(5, "R8");
    check("R8", lp_mode, 1'b1);
    pulse_after(5, "R7");
    check("R7", lp_mode, 1'b0);

    // R4: pulse inside the debounce window
    quiet(FI + 50, "R4");
    step(1, "R4");
    check("R4", lp_mode, 1'b0);
    quiet(FI + FD - 1, "R4");
    check("R4", lp_mode, 1'b0);
    step(0, "R4");
    check("R4", lp_mode, 1'b1);

    // random periods checked against the model
    for (int i = 0; i < 160; i++) begin
      int sel = int'($urandom % 4);
      int p;
      case (sel)
        0: p = 1 + int'($urandom % FN);
        1: p = FN + 1 + int'($urandom % (FG - FN));
        2: p = 1 + int'($urandom % (FI + FD + 40));
        default: p = FI + FD + int'($urandom % 100);
      endcase
      pulse_after(p, "R6");
    end

    // R3: slow limit set
    slow_variant = 1;
    do_reset();
    step(1, "R3");
    quiet(SI + SD - 1, "R3");
    check("R3", lp_mode, 1'b0);
    step(0, "R3");
    check("R3", lp_mode, 1'b1);
    pulse_after(700, "R3");
    pulse_after(60, "R3");
    check("R3", lp_mode, 1'b0);
    quiet(SI + SD, "R3");
    check("R3", lp_mode, 1'b1);
    pulse_after(700, "R3");
    for (int i = 0; i < 6; i++) pulse_after(SN, "R3");
    check("R3", lp_mode, 1'b1);
    pulse_after(SN, "R3");
    check("R3", lp_mode, 1'b0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule